// File: doc/BRIEF.md
# Keypad Binary Word Entry Controller

This block scans a telephone-style keypad of four columns by three rows and builds a binary word from it, one bit for each keypress. It drives a 2-bit encoded column select and reads three active-low row lines. The rows pass through a synchronizer. The column code and the synchronized rows together form a key code, and that code is debounced as a whole. Only the '0' and '1' keys add data. The '*' key clears the entry. Every other key raises an invalid flag.

While a key is held, the column scan stops so the pressed key stays in view for the whole settle period. A press counts once, on the rising edge of the debounced "pressed" state. The number of stored bits is shown as two decimal digits on common-cathode 7-segment outputs. The stored bits drive two 8-LED rows. The complete word is presented once all bits are in.

Top module: `keypad_word_entry`

## Requirements
- R1: After reset `col_sel_o` is 0. While no single-row key is seen, it advances by one, wrapping 3 to 0, every 2^SCAN_LOG2 clocks. It holds its value while a single-row key is seen.
- R2: The key code is {column, row_ni[2:0]}. Row pattern 110 is row 0, 101 is row 1 and 011 is row 2. Columns 0 to 2 hold keys '1'-'3', '4'-'6' and '7'-'9' in row order. Column 3 holds '*', '0' and '#' in row order.
- R3: A press of '0' or '1' while fewer than WORD_BITS bits are stored does three things. It writes the bit at position WORD_BITS-1-count, so the first bit lands in the MSB. It increments the count. It clears `invalid_o`.
- R4: A press of '2'-'9' or '#' sets `invalid_o` and leaves the stored bits and the count unchanged.
- R5: A press of '*' clears the stored bits, the count and `invalid_o`. It leaves `word_o` unchanged.
- R6: When WORD_BITS bits are stored, a press of '0' or '1' stores nothing and sets `invalid_o`.
- R7: A key held down for any length of time adds exactly one bit. Releasing it and pressing it again adds another bit.
- R8: A row pattern must stay unchanged for SETTLE_CLKS clocks before it registers as a press. A contact that lasts for less than this time has no effect.
- R9: A pattern with more than one row low is ignored.
- R10: `seg_tens_o` and `seg_ones_o` show the count in decimal. The encoding is 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=27, 8=7F, 9=6F (hex). Both digits go blank (00) for a count above 99.
- R11: `led_row_a_o` shows stored bits [15:8] and `led_row_b_o` shows stored bits [7:0].
- R12: `word_o` loads the stored bits in the cycle the count reaches WORD_BITS and holds its value at every other time. After reset it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_ni | input | 3 | Keypad row lines, active low, asynchronous |
| col_sel_o | output | 2 | Encoded column select |
| invalid_o | output | 1 | Last press was rejected |
| seg_tens_o | output | 8 | Tens digit of the bit count, segments gfedcba in bits 6:0 |
| seg_ones_o | output | 8 | Ones digit of the bit count |
| led_row_a_o | output | 8 | Stored bits [15:8] |
| led_row_b_o | output | 8 | Stored bits [7:0] |
| word_o | output | 16 | Completed word |

## Verification
The checker watches several properties on every cycle. The column code only ever steps by one. The count only increments or returns to zero, and never passes the word length. The word output changes only at a full count. A rising invalid flag never comes with a change of count or bits. A zero count always shows "00". Other behaviour can only be shown by the bench's scenarios: the mapping from keys to bits, press-once on a long hold, rejection of short contacts and bounce, the handling of multi-row patterns, and the scan period. For these the bench drives a keypad model and compares every output against its own model on each clock outside the press windows.

// File: rtl/kpw_pkg.sv
package kpw_pkg;

  typedef enum logic [2:0] {
    KEY_NONE,
    KEY_ZERO,
    KEY_ONE,
    KEY_CLEAR,
    KEY_BAD
  } key_e;

  // code = {col[1:0], row_n[2:0]}
  function automatic key_e decode_key(input logic [4:0] code);
    logic [1:0] col;
    logic [2:0] rn;
    col = code[4:3];
    rn  = code[2:0];
    if (rn != 3'b110 && rn != 3'b101 && rn != 3'b011) return KEY_NONE;
    if (col == 2'd0 && rn == 3'b110) return KEY_ONE;
    if (col == 2'd3 && rn == 3'b101) return KEY_ZERO;
    if (col == 2'd3 && rn == 3'b110) return KEY_CLEAR;
    return KEY_BAD;
  endfunction

  function automatic logic [7:0] seg_of(input logic [3:0] d);
    case (d)
      4'd0:    return 8'h3F;
      4'd1:    return 8'h06;
      4'd2:    return 8'h5B;
      4'd3:    return 8'h4F;
      4'd4:    return 8'h66;
      4'd5:    return 8'h6D;
      4'd6:    return 8'h7D;
      4'd7:    return 8'h27;
      4'd8:    return 8'h7F;
      4'd9:    return 8'h6F;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/kpw_row_sync.sv
module kpw_row_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // no reset: a reset value could inject a false edge downstream
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) stage_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) stage_q[s] <= stage_q[s-1];
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/kpw_scan_debounce.sv
module kpw_scan_debounce #(
  parameter int SCAN_LOG2   = 11,
  parameter int SETTLE_CLKS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] rows_n_i,
  output logic [1:0] col_o,
  output logic [4:0] code_o,
  output logic       press_o
);
  localparam int TW = $clog2(SETTLE_CLKS + 1);

  logic [SCAN_LOG2-1:0] pre_q;
  logic [1:0]           col_q;
  logic [4:0]           code_q;
  logic [TW-1:0]        timer_q;
  logic                 pressed_q, pressed_d_q;
  logic                 single_low;
  logic [4:0]           cand;

  assign single_low = ($countones(~rows_n_i) == 1);
  assign cand       = {col_q, rows_n_i};

  // scan is frozen while a candidate key is visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      col_q <= '0;
    end else if (!single_low) begin
      pre_q <= pre_q + 1'b1;
      if (&pre_q) col_q <= col_q + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q      <= 5'b00111;
      timer_q     <= TW'(SETTLE_CLKS - 1);
      pressed_q   <= 1'b0;
      pressed_d_q <= 1'b0;
    end else begin
      pressed_d_q <= pressed_q;
      if (!single_low) begin
        timer_q   <= TW'(SETTLE_CLKS - 1);
        pressed_q <= 1'b0;
      end else if (cand != code_q) begin
        code_q    <= cand;
        timer_q   <= TW'(SETTLE_CLKS - 1);
        pressed_q <= 1'b0;
      end else if (timer_q == '0) begin
        pressed_q <= 1'b1;
      end else begin
        timer_q <= timer_q - 1'b1;
      end
    end
  end

  assign col_o   = col_q;
  assign code_o  = code_q;
  assign press_o = pressed_q & ~pressed_d_q;
endmodule

// File: rtl/kpw_word_acc.sv
module kpw_word_acc
  import kpw_pkg::*;
#(
  parameter int WORD_BITS = 16,
  localparam int CW = $clog2(WORD_BITS + 1),
  localparam int IW = $clog2(WORD_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 press_i,
  input  logic [4:0]           code_i,
  output logic [CW-1:0]        count_o,
  output logic [WORD_BITS-1:0] bits_o,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 invalid_o
);
  logic [CW-1:0]        count_q;
  logic [WORD_BITS-1:0] bits_q, bits_nx, word_q;
  logic                 inv_q;
  key_e                 key;
  logic                 room;

  assign key  = decode_key(code_i);
  assign room = (count_q < CW'(WORD_BITS));

  always_comb begin
    bits_nx = bits_q;
    if (room) bits_nx[IW'(WORD_BITS - 1) - count_q[IW-1:0]] = (key == KEY_ONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      bits_q  <= '0;
      word_q  <= '0;
      inv_q   <= 1'b0;
    end else if (press_i) begin
      unique case (key)
        KEY_CLEAR: begin
          count_q <= '0;
          bits_q  <= '0;
          inv_q   <= 1'b0;
        end
        KEY_ZERO, KEY_ONE: begin
          if (room) begin
            bits_q  <= bits_nx;
            count_q <= count_q + 1'b1;
            inv_q   <= 1'b0;
            if (count_q == CW'(WORD_BITS - 1)) word_q <= bits_nx;
          end else begin
            inv_q <= 1'b1;
          end
        end
        KEY_BAD:  inv_q <= 1'b1;
        default:  ;
      endcase
    end
  end

  assign count_o   = count_q;
  assign bits_o    = bits_q;
  assign word_o    = word_q;
  assign invalid_o = inv_q;
endmodule

// File: rtl/kpw_seg_display.sv
module kpw_seg_display
  import kpw_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [CW-1:0] count_i,
  output logic [7:0]    tens_o,
  output logic [7:0]    ones_o
);
  int unsigned v;

  always_comb begin
    v = 32'(count_i);
    if (v > 99) begin
      tens_o = 8'h00;
      ones_o = 8'h00;
    end else begin
      tens_o = seg_of(4'(v / 10));
      ones_o = seg_of(4'(v % 10));
    end
  end
endmodule

// File: rtl/keypad_word_entry.sv
module keypad_word_entry #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int SETTLE_NS = 10_000_000,
  parameter int SCAN_LOG2 = 11,
  parameter int SYNC_STG  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  row_ni,
  output logic [1:0]  col_sel_o,
  output logic        invalid_o,
  output logic [7:0]  seg_tens_o,
  output logic [7:0]  seg_ones_o,
  output logic [7:0]  led_row_a_o,
  output logic [7:0]  led_row_b_o,
  output logic [15:0] word_o
);
  localparam int WORD_BITS   = 16;
  localparam int CW          = $clog2(WORD_BITS + 1);
  localparam int SETTLE_RAW  = (CLK_HZ / 1_000_000) * SETTLE_NS / 1000;
  // settle must outlast the synchronizer so stale rows never register
  localparam int SETTLE_CLKS = (SETTLE_RAW > SYNC_STG + 2) ? SETTLE_RAW : SYNC_STG + 2;

  logic [2:0]           rows_s;
  logic [4:0]           code;
  logic                 press;
  logic [CW-1:0]        count;
  logic [WORD_BITS-1:0] bits;

  kpw_row_sync #(.WIDTH(3), .STAGES(SYNC_STG)) i_sync (
    .clk_i (clk_i),
    .d_i   (row_ni),
    .q_o   (rows_s)
  );

  kpw_scan_debounce #(.SCAN_LOG2(SCAN_LOG2), .SETTLE_CLKS(SETTLE_CLKS)) i_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rows_n_i (rows_s),
    .col_o    (col_sel_o),
    .code_o   (code),
    .press_o  (press)
  );

  kpw_word_acc #(.WORD_BITS(WORD_BITS)) i_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .press_i   (press),
    .code_i    (code),
    .count_o   (count),
    .bits_o    (bits),
    .word_o    (word_o),
    .invalid_o (invalid_o)
  );

  kpw_seg_display #(.CW(CW)) i_seg (
    .count_i (count),
    .tens_o  (seg_tens_o),
    .ones_o  (seg_ones_o)
  );

  assign led_row_a_o = bits[15:8];
  assign led_row_b_o = bits[7:0];
endmodule

// File: rtl/kpw_checker.sv
module kpw_checker #(
  parameter int WORD_BITS = 16,
  parameter int CW        = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [1:0]           col_sel_o,
  input logic                 invalid_o,
  input logic [7:0]           seg_tens_o,
  input logic [7:0]           seg_ones_o,
  input logic [WORD_BITS-1:0] word_o,
  input logic [CW-1:0]        count_i,
  input logic [WORD_BITS-1:0] bits_i
);
  AST_COL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_sel_o != $past(col_sel_o)) |-> (col_sel_o == 2'($past(col_sel_o) + 2'd1))); // R1

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i != $past(count_i)) |-> (count_i == '0 || count_i == CW'($past(count_i) + 1'b1))); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(WORD_BITS)); // R6

  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(count_i) == CW'(WORD_BITS) && count_i == CW'(WORD_BITS)) |-> $stable(bits_i)); // R6

  AST_BAD_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(invalid_o) |-> ($stable(count_i) && $stable(bits_i))); // R4

  AST_WORD_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_o) |-> (count_i == CW'(WORD_BITS))); // R12

  AST_SEG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0) |-> (seg_tens_o == 8'h3F && seg_ones_o == 8'h3F)); // R10
endmodule

bind keypad_word_entry kpw_checker #(.WORD_BITS(WORD_BITS), .CW(CW)) i_kpw_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .col_sel_o  (col_sel_o),
  .invalid_o  (invalid_o),
  .seg_tens_o (seg_tens_o),
  .seg_ones_o (seg_ones_o),
  .word_o     (word_o),
  .count_i    (count),
  .bits_i     (bits)
);

// File: tb/test_keypad_word_entry.sv
`timescale 1ns/1ps
module test_keypad_word_entry;
  localparam int SCAN_LOG2 = 4;
  localparam int SCAN_P    = 1 << SCAN_LOG2;
  localparam int SETTLE    = 12;              // 125 MHz * 96 ns
  localparam int WAITP     = 4 * SCAN_P + SETTLE + 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  row_n;
  logic [1:0]  col;
  logic        inv;
  logic [7:0]  st, so, la, lb;
  logic [15:0] word;

  always #4 clk = ~clk;

  keypad_word_entry #(.CLK_HZ(125_000_000), .SETTLE_NS(96), .SCAN_LOG2(SCAN_LOG2)) i_keypad_word_entry (
    .clk_i(clk), .rst_ni(rst_n), .row_ni(row_n), .col_sel_o(col), .invalid_o(inv),
    .seg_tens_o(st), .seg_ones_o(so), .led_row_a_o(la), .led_row_b_o(lb), .word_o(word)
  );

  // keypad model
  logic       k_on = 1'b0;
  logic [1:0] k_col = 2'd0;
  logic [2:0] k_mask = 3'b111;
  assign row_n = (k_on && col == k_col) ? k_mask : 3'b111;

  // reference model
  int          m_cnt = 0;
  logic [15:0] m_bits = '0;
  logic [15:0] m_word = '0;
  logic        m_inv = 1'b0;
  int          checks = 0;
  int          fails = 0;
  logic        cmp_on = 1'b0;
  logic        pending = 1'b0;
  string       cur_req = "R10";

  function automatic logic [7:0] seg_exp(int d);
    logic [7:0] t [10] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66, 8'h6D, 8'h7D, 8'h27, 8'h7F, 8'h6F};
    return t[d];
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !pending) begin
      check(cur_req, "count tens (R10)", st, seg_exp(m_cnt / 10));
      check(cur_req, "count ones (R10)", so, seg_exp(m_cnt % 10));
      check(cur_req, "led rows (R11)", {la, lb}, m_bits);
      check(cur_req, "word (R12)", word, m_word);
      check(cur_req, "invalid", inv, m_inv);
    end
  end

  // key: 0..9 digits, 10='*', 11='#'
  task automatic key_pos(int k, output logic [1:0] c, output logic [2:0] m);
    int r;
    if (k == 0)       begin c = 2'd3; r = 1; end
    else if (k == 10) begin c = 2'd3; r = 0; end
    else if (k == 11) begin c = 2'd3; r = 2; end
    else              begin c = 2'((k - 1) / 3); r = (k - 1) % 3; end
    m = ~(3'b001 << r);
  endtask

  task automatic model_apply(int k);
    if (k == 10) begin m_bits = '0; m_cnt = 0; m_inv = 1'b0; end
    else if (k == 0 || k == 1) begin
      if (m_cnt < 16) begin
        m_bits[15 - m_cnt] = (k == 1);
        m_cnt++;
        m_inv = 1'b0;
        if (m_cnt == 16) m_word = m_bits;
      end else m_inv = 1'b1;
    end else m_inv = 1'b1;
  endtask

  task automatic press(int k, int hold, string req);
    logic [1:0] c;
    logic [2:0] m;
    cur_req = req;
    key_pos(k, c, m);
    pending = 1'b1;
    k_col = c; k_mask = m; k_on = 1'b1;
    repeat (WAITP) @(negedge clk);
    model_apply(k);
    pending = 1'b0;
    repeat (hold) @(negedge clk);
    k_on = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t0;
    int t1;
    logic [1:0] c0;
    logic [1:0] cc;
    logic [2:0] mm;
    repeat (3) @(negedge clk);
    // R12 R10 R1: reset state
    check("R1", "col at reset", col, 0);
    check("R12", "word at reset", word, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1: scan period with no key
    @(negedge clk);
    c0 = col;
    while (col == c0) @(negedge clk);
    t0 = $time; c0 = col;
    while (col == c0) @(negedge clk);
    t1 = $time;
    check("R1", "scan period ns", t1 - t0, SCAN_P * 8);
    check("R1", "col step", col, 2'(c0 + 1));

    // R2 R3: data keys
    press(1, 0, "R3");
    press(0, 0, "R3");
    press(1, 0, "R2");
    // R4: invalid keys
    press(5, 0, "R4");
    press(11, 0, "R4");
    press(9, 0, "R4");
    press(1, 0, "R3");
    // R7: long hold counts once, column frozen while held
    press(0, 200, "R7");
    press(0, 0, "R7");

    // R9: two rows low on column 0
    cur_req = "R9";
    k_col = 2'd0; k_mask = 3'b100; k_on = 1'b1;
    repeat (WAITP * 2) @(negedge clk);
    k_on = 1'b0;
    repeat (10) @(negedge clk);

    // R8: short contact ignored
    cur_req = "R8";
    key_pos(1, cc, mm);
    k_col = cc; k_mask = mm;
    while (col != cc) @(negedge clk);
    k_on = 1'b1;
    repeat (SETTLE / 2) @(negedge clk);
    k_on = 1'b0;
    repeat (WAITP) @(negedge clk);

    // R8: bouncing contact registers once
    while (col != cc) @(negedge clk);
    pending = 1'b1;
    for (int i = 0; i < 3; i++) begin
      k_on = 1'b1; repeat (3) @(negedge clk);
      k_on = 1'b0; repeat (2) @(negedge clk);
    end
    k_on = 1'b1;
    repeat (WAITP) @(negedge clk);
    model_apply(1);
    pending = 1'b0;
    repeat (20) @(negedge clk);
    k_on = 1'b0;
    repeat (10) @(negedge clk);

    // R5: clear mid-entry
    press(10, 0, "R5");
    // fill to 16: R12, R6
    for (int i = 0; i < 16; i++) press((i % 3 == 0) ? 1 : 0, 0, "R12");
    check("R12", "word after fill", word, 16'b1001001001001001);
    press(1, 0, "R6");
    press(0, 0, "R6");
    press(4, 0, "R6");
    // R5: clear keeps word
    press(10, 0, "R5");
    check("R5", "word kept after clear", word, 16'b1001001001001001);
    for (int i = 0; i < 16; i++) press((i < 8) ? 1 : 0, 0, "R12");
    check("R12", "second word", word, 16'hFF00);
    press(10, 0, "R5");

    cmp_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule